// File: doc/BRIEF.md
# Boot-Time Memory Map Decoder

This block is the address decoder of a 24-bit CPU bus. It chooses which of four devices answers each bus cycle: the boot flash, main RAM, a legacy 1 MB peripheral bus, or the I/O window. The choice depends on the address, the read/write direction and a small mapping state that moves forward as the system boots. After power-on, decoding is turned off and the boot flash answers at every address, so the first vector fetch at address 0 reads flash. The boot code then turns decoding on. It does this either by running from the flash's own high address range or by writing the mapping register. From there, RAM sits at address 0 and can be loaded with an operating system image. After loading, the low part of RAM is write-protected.

A split state lets the boot code copy the legacy ROM in place. Reads of the low 48 KB come from the legacy bus and writes to the same addresses go to RAM. The mapping register is write-only and sits inside the I/O window. Software may rewrite it at any time, for example to load a different operating system. Only power-on reset returns the map to its boot state. A soft reset of the CPU leaves the mapping and the violation flag as they were.

The decode is purely combinational from the address and strobe, within one cycle. The only storage is the 2-bit mapping state, a sticky protection-violation flag and the previous strobe level used for edge detection.

Top module: `bootmap_decoder`

## Requirements
- R1: While `por_n` is low, and in the boot state that follows it, every strobed access selects only the flash, `ram_we` stays low and `dec_err` stays low, whatever the address or direction.
- R2: In the boot state, a strobed read whose address bit 23 is 1 switches the map to the load state, and the new map applies from the next clock cycle.
- R3: A strobed write to address 0x01BF00 loads the mapping state from `wdata[1:0]`: 01 selects load, 10 selects protect and 11 selects split. The write is taken only on the clock where the strobe rises, and it also works from the boot state.
- R4: A register write with `wdata[1:0]` = 00 leaves the mapping state unchanged. Once decoding is on, nothing but power-on reset brings back the boot state.
- R5: In every decoded state, addresses 0x018000 to 0x01BFFF select `cs_io`, including the register address itself.
- R6: In every decoded state, addresses 0x000000 to 0x3FFFFF outside the I/O window select `cs_ram`, except where R10 applies. In the load state a strobed write there raises `ram_we`.
- R7: In every decoded state, addresses 0xF00000 to 0xFFFFFF select `cs_legacy`.
- R8: In every decoded state, addresses 0xC00000 to 0xC7FFFF select `cs_flash`.
- R9: In the protect state, a strobed write below 0x00C000 still selects `cs_ram` but leaves `ram_we` low. Reads there go to RAM, and writes at 0x00C000 and above raise `ram_we`.
- R10: In the split state, strobed reads below 0x00C000 select `cs_legacy`, while writes to the same addresses select `cs_ram` with `ram_we` high.
- R11: In a decoded state, a strobed address that matches no region asserts no chip select and raises `dec_err`.
- R12: `prot_viol` rises on the clock after a blocked write's strobe rising edge. It stays high until a register write, which clears it from the next cycle.
- R13: Holding `soft_rst_n` low changes neither the mapping state nor `prot_viol`.
- R14: At most one chip select is high at any time, and none is high while `strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst_n | input | 1 | CPU soft reset, active low; does not affect the decoder |
| strobe | input | 1 | Bus cycle valid |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 24 | Byte address |
| wdata | input | 2 | Low data bits, used by mapping-register writes |
| cs_flash | output | 1 | Boot flash select |
| cs_ram | output | 1 | Main RAM select |
| cs_legacy | output | 1 | Legacy 1 MB bus select |
| cs_io | output | 1 | I/O window select |
| ram_we | output | 1 | RAM write enable |
| dec_err | output | 1 | Strobed address matched no region |
| prot_viol | output | 1 | Sticky protected-write flag |

## Verification
The bench builds the decoder with its default parameters. Both enable triggers are active, the protected region is 48 KB, RAM is 4 MB and the register sits at 0x01BF00. Power-on reset is applied twice, so each trigger opens decoding once: the flash-range read in one pass and the register write in the other. With the 48 KB boundary, the protect and split limits coincide at 0x00C000, so a single pair of accesses at 0x00BFFF and 0x00C000 probes the edge of both. With 4 MB of RAM, the gap between RAM and flash is large enough to reach the decode-error path.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    typedef enum logic [1:0] {
        MAP_BOOT  = 2'b00,
        MAP_LOAD  = 2'b01,
        MAP_PROT  = 2'b10,
        MAP_SPLIT = 2'b11
    } map_mode_e;

    typedef struct packed {
        logic flash;
        logic ram;
        logic legacy;
        logic io;
    } sel_t;

    typedef struct packed {
        map_mode_e mode;
        logic      viol;
        logic      strb;
    } ctrl_state_t;

endpackage

// File: rtl/bootmap_region_dec.sv
module bootmap_region_dec
    import bootmap_pkg::*;
#(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned RAM_BYTES   = 32'h0040_0000,
    parameter int unsigned IO_LO       = 32'h0001_8000,
    parameter int unsigned IO_HI       = 32'h0001_BFFF,
    parameter int unsigned FLASH_BASE  = 32'h00C0_0000,
    parameter int unsigned FLASH_BYTES = 32'h0008_0000,
    parameter int unsigned LEG_BASE    = 32'h00F0_0000,
    parameter int unsigned SPLIT_END   = 32'h0000_C000,
    parameter int unsigned PROT_END    = 32'h0000_C000
) (
    input  map_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output sel_t              sel,
    output logic              none,
    output logic              wr_block
);

    localparam logic [ADDR_W-1:0] IO_LO_A  = ADDR_W'(IO_LO);
    localparam logic [ADDR_W-1:0] IO_HI_A  = ADDR_W'(IO_HI);
    localparam logic [ADDR_W-1:0] LEG_A    = ADDR_W'(LEG_BASE);
    localparam logic [ADDR_W-1:0] FL_LO_A  = ADDR_W'(FLASH_BASE);
    localparam logic [ADDR_W-1:0] FL_HI_A  = ADDR_W'(FLASH_BASE + FLASH_BYTES - 1);
    localparam logic [ADDR_W-1:0] SPLIT_A  = ADDR_W'(SPLIT_END);
    localparam logic [ADDR_W-1:0] RAM_A    = ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] PROT_A   = ADDR_W'(PROT_END);

    logic in_io, in_leg, in_flash, in_low_split, in_ram, in_prot;

    always_comb begin
        in_io        = (addr >= IO_LO_A) && (addr <= IO_HI_A);
        in_leg       = (addr >= LEG_A);
        in_flash     = (addr >= FL_LO_A) && (addr <= FL_HI_A);
        in_low_split = (addr < SPLIT_A);
        in_ram       = (addr < RAM_A);
        in_prot      = (addr < PROT_A);
    end

    // Priority chain: boot alias, I/O window, high legacy alias, flash,
    // split-read window, RAM, nothing.
    always_comb begin
        sel      = '0;
        none     = 1'b0;
        wr_block = 1'b0;
        if (mode == MAP_BOOT) begin
            sel.flash = 1'b1;
        end else if (in_io) begin
            sel.io = 1'b1;
        end else if (in_leg) begin
            sel.legacy = 1'b1;
        end else if (in_flash) begin
            sel.flash = 1'b1;
        end else if ((mode == MAP_SPLIT) && !wr && in_low_split) begin
            sel.legacy = 1'b1;
        end else if (in_ram) begin
            sel.ram  = 1'b1;
            wr_block = (mode == MAP_PROT) && wr && in_prot;
        end else begin
            none = 1'b1;
        end
    end

endmodule

// File: rtl/bootmap_ctrl.sv
module bootmap_ctrl
    import bootmap_pkg::*;
#(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned REG_ADDR     = 32'h0001_BF00,
    parameter int unsigned TRIG_BIT     = 23,
    parameter bit          EN_ADDR_TRIG = 1'b1,
    parameter bit          EN_REG_TRIG  = 1'b1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic              strobe,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wdata,
    input  logic              wr_block,
    output map_mode_e         mode_q,
    output logic              viol_q
);

    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

    ctrl_state_t st_d, st_q;
    logic        start_edge;
    logic        reg_hit;
    logic        addr_trig;
    logic        reg_allowed;

    always_comb begin
        start_edge = strobe && !st_q.strb;
        reg_hit    = start_edge && wr && (addr == REG_A);
    end

    generate
        if (EN_ADDR_TRIG) begin : g_addr_trig
            always_comb addr_trig = start_edge && !wr && addr[TRIG_BIT]
                                    && (st_q.mode == MAP_BOOT);
        end else begin : g_no_addr_trig
            always_comb addr_trig = 1'b0;
        end
        if (EN_REG_TRIG) begin : g_reg_trig
            always_comb reg_allowed = 1'b1;
        end else begin : g_no_reg_trig
            always_comb reg_allowed = (st_q.mode != MAP_BOOT);
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.strb = strobe;
        if (reg_hit) begin
            st_d.viol = 1'b0;
            if ((wdata != 2'b00) && reg_allowed) begin
                st_d.mode = map_mode_e'(wdata);
            end
        end else if (addr_trig) begin
            st_d.mode = MAP_LOAD;
        end
        if (start_edge && wr_block) begin
            st_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{mode: MAP_BOOT, viol: 1'b0, strb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign viol_q = st_q.viol;

    // R4: once out of boot, only power-on reset returns there
    a_r4_no_return_to_boot: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.mode != MAP_BOOT) |=> (st_q.mode != MAP_BOOT));

    // R12: violation flag holds until a register write
    a_r12_viol_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.viol && !(strobe && wr && (addr == REG_A))) |=> st_q.viol);

    // R13: a held soft reset with an idle bus leaves state alone
    a_r13_soft_reset_inert: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst_n && !strobe) |=> ($stable(st_q.mode) && $stable(st_q.viol)));

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned RAM_BYTES    = 32'h0040_0000,
    parameter int unsigned IO_LO        = 32'h0001_8000,
    parameter int unsigned IO_HI        = 32'h0001_BFFF,
    parameter int unsigned REG_ADDR     = 32'h0001_BF00,
    parameter int unsigned FLASH_BASE   = 32'h00C0_0000,
    parameter int unsigned FLASH_BYTES  = 32'h0008_0000,
    parameter int unsigned LEG_BASE     = 32'h00F0_0000,
    parameter int unsigned LEG_ROM_END  = 32'h0000_C000,
    parameter bit          PROT_64K     = 1'b0,
    parameter int unsigned TRIG_BIT     = 23,
    parameter bit          EN_ADDR_TRIG = 1'b1,
    parameter bit          EN_REG_TRIG  = 1'b1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic              strobe,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wdata,
    output logic              cs_flash,
    output logic              cs_ram,
    output logic              cs_legacy,
    output logic              cs_io,
    output logic              ram_we,
    output logic              dec_err,
    output logic              prot_viol
);

    localparam int unsigned PROT_END = PROT_64K ? 32'h0001_0000 : 32'h0000_C000;
    localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_END);

    map_mode_e mode_q;
    sel_t      sel;
    logic      none;
    logic      wr_block;

    bootmap_region_dec #(
        .ADDR_W      (ADDR_W),
        .RAM_BYTES   (RAM_BYTES),
        .IO_LO       (IO_LO),
        .IO_HI       (IO_HI),
        .FLASH_BASE  (FLASH_BASE),
        .FLASH_BYTES (FLASH_BYTES),
        .LEG_BASE    (LEG_BASE),
        .SPLIT_END   (LEG_ROM_END),
        .PROT_END    (PROT_END)
    ) u_dec (
        .mode     (mode_q),
        .addr     (addr),
        .wr       (wr),
        .sel      (sel),
        .none     (none),
        .wr_block (wr_block)
    );

    bootmap_ctrl #(
        .ADDR_W       (ADDR_W),
        .REG_ADDR     (REG_ADDR),
        .TRIG_BIT     (TRIG_BIT),
        .EN_ADDR_TRIG (EN_ADDR_TRIG),
        .EN_REG_TRIG  (EN_REG_TRIG)
    ) u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .strobe     (strobe),
        .wr         (wr),
        .addr       (addr),
        .wdata      (wdata),
        .wr_block   (wr_block),
        .mode_q     (mode_q),
        .viol_q     (prot_viol)
    );

    always_comb begin
        cs_flash  = strobe && sel.flash;
        cs_ram    = strobe && sel.ram;
        cs_legacy = strobe && sel.legacy;
        cs_io     = strobe && sel.io;
        ram_we    = strobe && wr && sel.ram && !wr_block;
        dec_err   = strobe && none;
    end

    // R14: never more than one select
    a_r14_onehot_cs: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({cs_flash, cs_ram, cs_legacy, cs_io}));

    // R1: boot state aliases flash everywhere
    a_r1_boot_alias: assert property (@(posedge clk) disable iff (!por_n)
        (strobe && (mode_q == MAP_BOOT)) |-> (cs_flash && !ram_we && !dec_err));

    // R9: no RAM write enable into the protected region
    a_r9_prot_blocks_we: assert property (@(posedge clk) disable iff (!por_n)
        (strobe && wr && (mode_q == MAP_PROT) && (addr < PROT_A)) |-> !ram_we);

    // R11: a decode error carries no select
    a_r11_err_no_cs: assert property (@(posedge clk) disable iff (!por_n)
        dec_err |-> !(cs_flash || cs_ram || cs_legacy || cs_io));

endmodule

// File: tb/sim_bootmap_decoder.sv
module sim_bootmap_decoder;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [23:0] REG_A = 24'h01BF00;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        strobe = 1'b0;
    logic        wr = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  wdata = '0;
    logic        cs_flash, cs_ram, cs_legacy, cs_io, ram_we, dec_err, prot_viol;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_mode = 0;     // 0 boot, 1 load, 2 protect, 3 split
    bit m_viol = 0;
    bit m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootmap_decoder u0 (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .strobe(strobe),
        .wr(wr), .addr(addr), .wdata(wdata),
        .cs_flash(cs_flash), .cs_ram(cs_ram), .cs_legacy(cs_legacy), .cs_io(cs_io),
        .ram_we(ram_we), .dec_err(dec_err), .prot_viol(prot_viol)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
        end
    endtask

    // region code: 8 flash, 4 ram, 2 legacy, 1 io, 0 none
    function automatic int ref_region(int mode, logic [23:0] a, bit w);
        if (mode == 0) return 8;
        if (a >= 24'h018000 && a <= 24'h01BFFF) return 1;
        if (a >= 24'hF00000) return 2;
        if (a >= 24'hC00000 && a <= 24'hC7FFFF) return 8;
        if (mode == 3 && !w && a < 24'h00C000) return 2;
        if (a < 24'h400000) return 4;
        return 0;
    endfunction

    task automatic step(input logic [23:0] a, input bit w, input bit s,
                        input logic [1:0] d, input string tag);
        int reg_exp;
        bit we_exp, err_exp, blocked;
        @(negedge clk);
        addr = a; wr = w; strobe = s; wdata = d;
        #1;
        reg_exp = s ? ref_region(m_mode, a, w) : 0;
        blocked = (m_mode == 2) && w && (a < 24'h00C000) && (reg_exp == 4);
        we_exp  = s && w && (reg_exp == 4) && !blocked;
        err_exp = s && (m_mode != 0) && (reg_exp == 0);
        check({cs_flash, cs_ram, cs_legacy, cs_io} == 4'(reg_exp), tag, "chip selects",
              int'({cs_flash, cs_ram, cs_legacy, cs_io}), reg_exp);
        check({ram_we, dec_err} == {we_exp, err_exp}, tag, "ram_we/dec_err",
              int'({ram_we, dec_err}), int'({we_exp, err_exp}));
        check(prot_viol == m_viol, tag, "prot_viol", int'(prot_viol), int'(m_viol));
        @(posedge clk);
        if (s && !m_prev) begin
            if (w && a == REG_A) begin
                m_viol = 0;
                if (d != 2'b00) m_mode = int'(d);
            end else if (m_mode == 0 && !w && a[23]) begin
                m_mode = 1;
            end
            if (blocked) m_viol = 1;
        end
        m_prev = s;
    endtask

    task automatic rd(input logic [23:0] a, input string tag);
        step(a, 1'b0, 1'b1, 2'b00, tag);
        step(a, 1'b0, 1'b0, 2'b00, tag);
    endtask

    task automatic wt(input logic [23:0] a, input string tag);
        step(a, 1'b1, 1'b1, 2'b00, tag);
        step(a, 1'b1, 1'b0, 2'b00, tag);
    endtask

    task automatic regw(input logic [1:0] d, input string tag);
        step(REG_A, 1'b1, 1'b1, d, tag);
        step(REG_A, 1'b1, 1'b0, d, tag);
    endtask

    task automatic power_on;
        @(negedge clk);
        por_n = 1'b0; strobe = 1'b0; wr = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        check({cs_flash, cs_ram, cs_legacy, cs_io, ram_we, dec_err, prot_viol} == 7'b0,
              "R1", "reset outputs",
              int'({cs_flash, cs_ram, cs_legacy, cs_io, ram_we, dec_err, prot_viol}), 0);
        @(negedge clk);
        por_n = 1'b1;
        m_mode = 0; m_viol = 0; m_prev = 0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        power_on();
        // R1: boot alias everywhere
        rd(24'h000000, "R1");
        rd(24'h018004, "R1");
        wt(24'h000100, "R1");
        rd(24'h500000, "R1");
        // R14: strobe low selects nothing
        step(24'h000000, 1'b0, 1'b0, 2'b00, "R14");
        // R2: address trigger via flash high range
        rd(24'hC00010, "R2");
        rd(24'h000000, "R2");
        // R6: RAM read/write in load
        wt(24'h000100, "R6");
        rd(24'h3FFFFF, "R6");
        // R5, R7, R8, R11
        rd(24'h018004, "R5");
        rd(24'h01BFFF, "R5");
        wt(REG_A + 24'h4, "R5");
        rd(24'hF00100, "R7");
        rd(24'hF0BFFF, "R7");
        rd(24'hC7FFFF, "R8");
        rd(24'hC80000, "R11");
        rd(24'h400000, "R11");
        // R4: writing 00 keeps the state
        regw(2'b00, "R4");
        wt(24'h000200, "R4");
        // R3 / R10: split
        regw(2'b11, "R3");
        rd(24'h000100, "R10");
        wt(24'h000100, "R10");
        rd(24'h00BFFF, "R10");
        rd(24'h00C000, "R10");
        rd(24'hF00000, "R7");
        // R3: strobe held high over two clocks is one write; second edge needed
        step(REG_A, 1'b1, 1'b1, 2'b10, "R3");
        step(REG_A, 1'b1, 1'b1, 2'b01, "R3");
        step(REG_A, 1'b1, 1'b0, 2'b01, "R3");
        // now protect
        rd(24'h000100, "R9");
        wt(24'h000100, "R9");
        step(24'h0, 1'b0, 1'b0, 2'b00, "R12");
        wt(24'h00BFFF, "R9");
        wt(24'h00C000, "R9");
        rd(24'h018000, "R5");
        // R13: soft reset leaves map and flag
        @(negedge clk); soft_rst_n = 1'b0;
        step(24'h0, 1'b0, 1'b0, 2'b00, "R13");
        step(24'h0, 1'b0, 1'b0, 2'b00, "R13");
        @(negedge clk); soft_rst_n = 1'b1;
        wt(24'h000300, "R13");
        // R12: register write clears flag; R3 back to load
        regw(2'b01, "R12");
        wt(24'h000300, "R12");
        // R4: second power-on returns to boot; R3 register trigger
        power_on();
        rd(24'h000000, "R4");
        regw(2'b01, "R3");
        wt(24'h000000, "R3");
        rd(24'h018000, "R5");
        regw(2'b10, "R3");
        wt(24'h000000, "R9");
        done = 1;
        finish_run();
    end

endmodule